// File: doc/BRIEF.md
# DAC Code Correction Datapath

This block turns a stored, left-justified conversion word into the corrected code that drives a converter's modulator. It keeps three byte-writable registers: a data word, a signed offset and a full-scale gain. On each update it truncates the data word to the selected resolution, converts it from the selected number format, adds the offset, scales the result by the gain and clamps it to the unsigned code range. The corrected code is held in an output register, and a one-cycle flag marks each change.

Register writes arrive as byte strobes with a byte address. A separate strobe marks the end of a write command. The output is recomputed only when the operating mode is normal. Writes made in sleep or self-calibration mode are stored, and they reach the output on the next entry into normal mode. Two pulse inputs clear the data word and restore the calibration pair to their reset values.

Top module: `dac_code_cal`

## Requirements
- R1: After reset `codeOut` is 0 and `codeValid` is 0. The data word and the offset reset to 0 and the gain resets to 800000h. The first update therefore yields 800000h when the format is offset two's complement.
- R2: Byte address 0, 1 and 2 write data bits [7:0], [15:8] and [23:16]. Addresses 4, 5 and 6 write the offset bytes in the same order, and addresses 8, 9 and 10 write the gain bytes. Any other address writes nothing.
- R3: With `res20`=0 only data bits [23:8] are used. With `res20`=1 only bits [23:4] are used. In 16-bit mode, a write to data byte 0 leaves `codeOut` unchanged.
- R4: With `fmtStraight`=1 the truncated code is used as is. With `fmtStraight`=0 its bit 23 is inverted, so a code of 0 gives 800000h.
- R5: The offset is a 24-bit two's-complement value added to the formatted code. A sum below 0 gives 0, and a sum above FFFFFFh gives FFFFFFh.
- R6: The clamped sum is multiplied by the gain and shifted right by 23, so 800000h is unity gain. A result above FFFFFFh gives FFFFFFh.
- R7: Suppose `wrDone` is sampled high in normal mode, and a register byte was written since the previous `wrDone` (or in the same cycle). Then `codeOut` takes the new value at the following clock edge. Writes without `wrDone`, and a `wrDone` with no write, leave `codeOut` unchanged.
- R8: `modeSel` 00 is normal, 01 is self-calibration, and 10 or 11 is sleep. Outside normal mode the register writes are stored and `codeOut` holds. The edge that first samples normal mode after another mode starts an update, which reaches `codeOut` one edge later.
- R9: `clrData` sets the data word to 0, and `calRst` sets the offset to 0 and the gain to 800000h. Each of these takes priority over a register write in the same cycle. In normal mode each pulse starts an update, with the same timing as R7.
- R10: `codeValid` is high for exactly one cycle, in the cycle in which `codeOut` takes a value different from its previous one. An update that produces the same value raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Byte write strobe |
| wrAddr | input | 4 | Byte address of the write |
| wrByte | input | 8 | Byte to write |
| wrDone | input | 1 | End of the current write command |
| modeSel | input | 2 | Operating mode: 00 normal, 01 self-calibration, 1x sleep |
| res20 | input | 1 | 1 selects 20-bit resolution, 0 selects 16-bit |
| fmtStraight | input | 1 | 1 selects straight binary, 0 selects offset two's complement |
| clrData | input | 1 | Pulse that clears the data word |
| calRst | input | 1 | Pulse that restores the offset and gain |
| codeOut | output | 24 | Corrected code |
| codeValid | output | 1 | One-cycle pulse when codeOut changes |

## Verification
The bench uses the default parameters: three byte lanes of eight bits, a 24-bit code, resolutions of 16 and 20 bits, and byte bases 0, 4 and 8. With a full 24-bit offset and gain, the sum can be driven past both ends of the range and the product past the top, so every clamp can be reached with a single register write. With two resolutions that differ by four bits, a write to the lowest data byte can be shown to have no effect in one resolution and a visible effect in the other.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int MAX_BYTES = 4;

  typedef enum logic [1:0] {
    MODE_NORMAL    = 2'b00,
    MODE_SELFCAL   = 2'b01,
    MODE_SLEEP     = 2'b10,
    MODE_SLEEP_ALT = 2'b11
  } opMode_e;

  typedef enum logic [1:0] {
    REG_NONE,
    REG_DATA,
    REG_OFFSET,
    REG_GAIN
  } regSel_e;

  typedef struct packed {
    regSel_e              regSel;
    logic [MAX_BYTES-1:0] byteSel;
    logic                 clearData;
    logic                 resetCal;
    logic                 loadOut;
  } ctrlStrobe_t;
endpackage

// File: rtl/dcc_ctrl.sv
module dcc_ctrl
  import dcc_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int NUM_BYTES   = 3,
  parameter int DATA_BASE   = 0,
  parameter int OFFSET_BASE = 4,
  parameter int GAIN_BASE   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrDone,
  input  logic [1:0]        modeSel,
  input  logic              clrData,
  input  logic              calRst,
  output ctrlStrobe_t       strb
);
  regSel_e              hitSel;
  logic [MAX_BYTES-1:0] hitByte;
  logic                 writeHit;
  logic                 touchedQ;
  logic                 prevNormalQ;
  logic                 loadQ;
  logic                 isNormal;
  logic                 enterNormal;
  logic                 cmdUpdate;

  // Byte address decode: each register occupies NUM_BYTES consecutive addresses.
  always_comb begin
    hitSel  = REG_NONE;
    hitByte = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (wrAddr == ADDR_W'(DATA_BASE + b)) begin
        hitSel     = REG_DATA;
        hitByte[b] = 1'b1;
      end
      if (wrAddr == ADDR_W'(OFFSET_BASE + b)) begin
        hitSel     = REG_OFFSET;
        hitByte[b] = 1'b1;
      end
      if (wrAddr == ADDR_W'(GAIN_BASE + b)) begin
        hitSel     = REG_GAIN;
        hitByte[b] = 1'b1;
      end
    end
  end

  assign writeHit    = wrEn && (hitSel != REG_NONE);
  assign isNormal    = (opMode_e'(modeSel) == MODE_NORMAL);
  assign enterNormal = isNormal && !prevNormalQ;
  assign cmdUpdate   = wrDone && (touchedQ || writeHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      touchedQ    <= 1'b0;
      prevNormalQ <= 1'b0;
      loadQ       <= 1'b0;
    end else begin
      if (wrDone)        touchedQ <= 1'b0;
      else if (writeHit) touchedQ <= 1'b1;
      prevNormalQ <= isNormal;
      loadQ       <= isNormal && (cmdUpdate || clrData || calRst || enterNormal);
    end
  end

  always_comb begin
    strb.regSel    = wrEn ? hitSel : REG_NONE;
    strb.byteSel   = wrEn ? hitByte : '0;
    strb.clearData = clrData;
    strb.resetCal  = calRst;
    strb.loadOut   = loadQ;
  end

  // R8: no output load is requested while the mode is not normal
  p_sleep_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != MODE_NORMAL) |=> !loadQ)
    else $error("p_sleep_holds_r8");

  // R7: completion of a command that wrote a data byte requests a load
  p_done_loads_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_NORMAL && wrDone && wrEn && wrAddr == ADDR_W'(DATA_BASE)) |=> loadQ)
    else $error("p_done_loads_r7");

  // R8: entering normal mode requests a load
  p_entry_loads_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_NORMAL && $past(modeSel) != MODE_NORMAL) |=> loadQ)
    else $error("p_entry_loads_r8");
endmodule

// File: rtl/dcc_datapath.sv
module dcc_datapath
  import dcc_pkg::*;
#(
  parameter int NUM_BYTES = 3,
  parameter int BYTE_W    = 8,
  parameter int HI_RES    = 20,
  parameter int LO_RES    = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strb,
  input  logic [BYTE_W-1:0]           wrByte,
  input  logic                        res20,
  input  logic                        fmtStraight,
  output logic [NUM_BYTES*BYTE_W-1:0] codeOut,
  output logic                        codeValid
);
  localparam int DATA_W = NUM_BYTES * BYTE_W;
  localparam logic [DATA_W-1:0] GAIN_UNITY = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W-1:0] MAX_CODE   = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] MASK_HI    = ~((DATA_W'(1) << (DATA_W - HI_RES)) - DATA_W'(1));
  localparam logic [DATA_W-1:0] MASK_LO    = ~((DATA_W'(1) << (DATA_W - LO_RES)) - DATA_W'(1));

  logic [BYTE_W-1:0]     dataLane [NUM_BYTES];
  logic [BYTE_W-1:0]     offLane  [NUM_BYTES];
  logic [BYTE_W-1:0]     gainLane [NUM_BYTES];
  logic [DATA_W-1:0]     dataVec;
  logic [DATA_W-1:0]     offVec;
  logic [DATA_W-1:0]     gainVec;
  logic [DATA_W-1:0]     truncCode;
  logic [DATA_W-1:0]     fmtCode;
  logic signed [DATA_W+1:0] sumWide;
  logic [DATA_W-1:0]     sumSat;
  logic [2*DATA_W-1:0]   prodWide;
  logic [DATA_W:0]       scaled;
  logic [DATA_W-1:0]     corrCode;

  // Register byte lanes; clear and calibration reset win over a same-cycle write.
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataLane[b] <= '0;
        offLane[b]  <= '0;
        gainLane[b] <= GAIN_UNITY[b*BYTE_W +: BYTE_W];
      end else begin
        if (strb.clearData)
          dataLane[b] <= '0;
        else if (strb.regSel == REG_DATA && strb.byteSel[b])
          dataLane[b] <= wrByte;

        if (strb.resetCal) begin
          offLane[b]  <= '0;
          gainLane[b] <= GAIN_UNITY[b*BYTE_W +: BYTE_W];
        end else begin
          if (strb.regSel == REG_OFFSET && strb.byteSel[b]) offLane[b]  <= wrByte;
          if (strb.regSel == REG_GAIN && strb.byteSel[b])   gainLane[b] <= wrByte;
        end
      end
    end
    assign dataVec[b*BYTE_W +: BYTE_W] = dataLane[b];
    assign offVec[b*BYTE_W +: BYTE_W]  = offLane[b];
    assign gainVec[b*BYTE_W +: BYTE_W] = gainLane[b];
  end

  if (NUM_BYTES < MAX_BYTES) begin : g_spare
    logic unusedByteSel;
    assign unusedByteSel = ^strb.byteSel[MAX_BYTES-1:NUM_BYTES];
  end

  // Correction chain: truncate, format, offset with clamp, gain with clamp.
  always_comb begin
    truncCode = dataVec & (res20 ? MASK_HI : MASK_LO);
    fmtCode   = fmtStraight ? truncCode : {~truncCode[DATA_W-1], truncCode[DATA_W-2:0]};
    sumWide   = $signed({2'b00, fmtCode}) + $signed({{2{offVec[DATA_W-1]}}, offVec});
    if (sumWide[DATA_W+1])   sumSat = '0;
    else if (sumWide[DATA_W]) sumSat = MAX_CODE;
    else                      sumSat = sumWide[DATA_W-1:0];
    prodWide = {{DATA_W{1'b0}}, sumSat} * {{DATA_W{1'b0}}, gainVec};
    scaled   = prodWide[2*DATA_W-1:DATA_W-1];
    corrCode = scaled[DATA_W] ? MAX_CODE : scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeOut   <= '0;
      codeValid <= 1'b0;
    end else if (strb.loadOut) begin
      codeOut   <= corrCode;
      codeValid <= (corrCode != codeOut);
    end else begin
      codeValid <= 1'b0;
    end
  end

  // R10: the flag only accompanies a real change of the output
  p_valid_changes_r10: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |-> (codeOut != $past(codeOut)))
    else $error("p_valid_changes_r10");

  // R7: without a load request the output holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadOut |=> $stable(codeOut))
    else $error("p_hold_r7");

  // R9: clear empties the data word regardless of a concurrent write
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearData |=> (dataVec == '0))
    else $error("p_clear_r9");

  // R9: calibration reset restores offset and unity gain
  p_calrst_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.resetCal |=> (offVec == '0 && gainVec == GAIN_UNITY))
    else $error("p_calrst_r9");
endmodule

// File: rtl/dac_code_cal.sv
module dac_code_cal
  import dcc_pkg::*;
#(
  parameter int NUM_BYTES   = 3,
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int HI_RES      = 20,
  parameter int LO_RES      = 16,
  parameter int DATA_BASE   = 0,
  parameter int OFFSET_BASE = 4,
  parameter int GAIN_BASE   = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [BYTE_W-1:0]           wrByte,
  input  logic                        wrDone,
  input  logic [1:0]                  modeSel,
  input  logic                        res20,
  input  logic                        fmtStraight,
  input  logic                        clrData,
  input  logic                        calRst,
  output logic [NUM_BYTES*BYTE_W-1:0] codeOut,
  output logic                        codeValid
);
  ctrlStrobe_t strb;

  dcc_ctrl #(
    .ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .DATA_BASE(DATA_BASE),
    .OFFSET_BASE(OFFSET_BASE), .GAIN_BASE(GAIN_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrDone(wrDone),
    .modeSel(modeSel), .clrData(clrData), .calRst(calRst), .strb(strb)
  );

  dcc_datapath #(
    .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W), .HI_RES(HI_RES), .LO_RES(LO_RES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrByte(wrByte), .res20(res20),
    .fmtStraight(fmtStraight), .codeOut(codeOut), .codeValid(codeValid)
  );
endmodule

// File: tb/dac_code_cal_tb.sv
`timescale 1ns/1ps
module dac_code_cal_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [7:0]  wrByte = '0;
  logic        wrDone = 1'b0;
  logic [1:0]  modeSel = 2'b10;
  logic        res20 = 1'b0;
  logic        fmtStraight = 1'b0;
  logic        clrData = 1'b0;
  logic        calRst = 1'b0;
  logic [23:0] codeOut;
  logic        codeValid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [23:0] shData = '0, shOff = '0, shGain = 24'h800000;
  logic [23:0] lastExp = '0;
  bit touched = 0;
  logic [23:0] expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  dac_code_cal u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrByte(wrByte),
    .wrDone(wrDone), .modeSel(modeSel), .res20(res20), .fmtStraight(fmtStraight),
    .clrData(clrData), .calRst(calRst), .codeOut(codeOut), .codeValid(codeValid)
  );

  // Expected code from R3..R6.
  function automatic logic [23:0] model(logic [23:0] d, logic [23:0] o, logic [23:0] g,
                                        logic r20, logic fs);
    logic [23:0] t;
    longint s, p;
    t = r20 ? (d & 24'hFFFFF0) : (d & 24'hFFFF00);
    if (!fs) t[23] = ~t[23];
    s = longint'(t) + longint'($signed(o));
    if (s < 0) s = 0;
    else if (s > longint'(24'hFFFFFF)) s = longint'(24'hFFFFFF);
    p = (s * longint'(g)) >>> 23;
    if (p > longint'(24'hFFFFFF)) p = longint'(24'hFFFFFF);
    return p[23:0];
  endfunction

  // Monitor: pops one expected item per valid pulse (R10).
  always @(negedge clk) begin
    if (rstN && codeValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected valid, codeOut=%h expected no change from %h", codeOut, lastExp);
      end else begin
        logic [23:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (codeOut !== e) begin
          errors++;
          $display("FAIL %s: codeOut=%h expected %h", t, codeOut, e);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectUpdate(string tag);
    logic [23:0] e;
    if (modeSel == 2'b00) begin
      e = model(shData, shOff, shGain, res20, fmtStraight);
      if (e != lastExp) begin
        expQ.push_back(e);
        tagQ.push_back(tag);
        lastExp = e;
      end
    end
  endtask

  task automatic settle(string tag);
    tick(4);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL %s: missing update, codeOut=%h expected %h", tag, codeOut, expQ[0]);
      expQ.delete();
      tagQ.delete();
    end
  endtask

  task automatic checkHold(string tag);
    checks++;
    if (codeOut !== lastExp) begin
      errors++;
      $display("FAIL %s: codeOut=%h expected %h", tag, codeOut, lastExp);
    end
  endtask

  task automatic shadowWrite(logic [3:0] a, logic [7:0] v);
    case (a)
      4'd0: shData[7:0] = v;   4'd1: shData[15:8] = v;  4'd2: shData[23:16] = v;
      4'd4: shOff[7:0] = v;    4'd5: shOff[15:8] = v;   4'd6: shOff[23:16] = v;
      4'd8: shGain[7:0] = v;   4'd9: shGain[15:8] = v;  4'd10: shGain[23:16] = v;
      default: ;
    endcase
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] v);
    wrEn = 1'b1; wrAddr = a; wrByte = v;
    @(negedge clk);
    wrEn = 1'b0;
    shadowWrite(a, v);
    if (a inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9, 4'd10}) touched = 1;
  endtask

  task automatic wr24(logic [3:0] base, logic [23:0] v);
    wr(base, v[7:0]);
    wr(base + 4'd1, v[15:8]);
    wr(base + 4'd2, v[23:16]);
  endtask

  task automatic done(string tag);
    wrDone = 1'b1;
    @(negedge clk);
    wrDone = 1'b0;
    if (touched) expectUpdate(tag);
    touched = 0;
    settle(tag);
  endtask

  task automatic setMode(logic [1:0] m, string tag);
    bit wasNormal;
    wasNormal = (modeSel == 2'b00);
    modeSel = m;
    @(negedge clk);
    if (m == 2'b00 && !wasNormal) expectUpdate(tag);
    settle(tag);
  endtask

  task automatic pulseClear(string tag);
    clrData = 1'b1;
    @(negedge clk);
    clrData = 1'b0;
    shData = '0;
    expectUpdate(tag);
    settle(tag);
  endtask

  task automatic pulseCalRst(string tag);
    calRst = 1'b1;
    @(negedge clk);
    calRst = 1'b0;
    shOff = '0;
    shGain = 24'h800000;
    expectUpdate(tag);
    settle(tag);
  endtask

  initial begin
    tick(3);
    checks++;
    if (codeOut !== 24'h0 || codeValid !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset codeOut=%h valid=%b expected 000000 0", codeOut, codeValid);
    end
    rstN = 1'b1;
    tick(2);

    // R1/R8: entering normal mode with reset constants gives mid-scale
    setMode(2'b00, "R1 reset constants");
    checkHold("R1 mid-scale value");
    checks++;
    if (codeOut !== 24'h800000) begin
      errors++;
      $display("FAIL R1: codeOut=%h expected 800000", codeOut);
    end

    // R2/R4: 16-bit offset two's complement data write
    wr24(4'd0, 24'h123456);
    done("R2 data bytes");

    // R3: low byte write in 16-bit mode has no effect
    wr(4'd0, 8'hA7);
    done("R3 low byte ignored");
    checkHold("R3 16-bit hold");

    // R3: 20-bit mode brings data bits [7:4] into the code
    res20 = 1'b1;
    wr(4'd0, 8'hB3);
    done("R3 20-bit low nibble");

    // R4: zero code in both formats
    fmtStraight = 1'b1;
    wr24(4'd0, 24'h000000);
    done("R4 straight zero");
    fmtStraight = 1'b0;
    wr(4'd2, 8'h00);
    done("R4 offset format zero");

    // R5: offset add and both clamps
    fmtStraight = 1'b1;
    res20 = 1'b0;
    wr24(4'd0, 24'h100000);
    wr24(4'd4, 24'h000300);
    done("R5 offset add");
    wr24(4'd4, 24'hE00000);
    done("R5 floor clamp");
    wr24(4'd0, 24'hFFFF00);
    wr24(4'd4, 24'h000200);
    done("R5 ceiling clamp");

    // R6: gain scaling and clamp
    wr24(4'd4, 24'h000000);
    wr24(4'd8, 24'h400000);
    wr24(4'd0, 24'h123400);
    done("R6 half gain");
    wr24(4'd8, 24'hFFFFFF);
    wr24(4'd0, 24'hC00000);
    done("R6 gain clamp");

    // R9: calibration reset restores unity gain and zero offset
    pulseCalRst("R9 cal reset");

    // R7: no update before command completion, then update on completion
    wr(4'd2, 8'h55);
    tick(4);
    checkHold("R7 no update before done");
    done("R7 update on done");

    // R7: completion with no write does nothing
    done("R7 empty command");
    checkHold("R7 empty command hold");

    // R8: sleep and self-calibration hold stored writes
    setMode(2'b10, "R8 enter sleep");
    wr24(4'd0, 24'h345600);
    wr24(4'd4, 24'h001000);
    done("R8 sleep write");
    checkHold("R8 sleep hold");
    setMode(2'b01, "R8 self-cal");
    checkHold("R8 self-cal hold");
    setMode(2'b00, "R8 entry applies stored");

    // R9: clear in normal mode
    pulseClear("R9 clear data");

    // R9: clear wins over a same-cycle write
    wr24(4'd0, 24'h654300);
    done("R9 prep write");
    clrData = 1'b1; wrEn = 1'b1; wrAddr = 4'd2; wrByte = 8'h77;
    @(negedge clk);
    clrData = 1'b0; wrEn = 1'b0;
    shData = '0;
    touched = 1;
    expectUpdate("R9 clear wins");
    settle("R9 clear wins");
    done("R9 clear wins done");
    checkHold("R9 clear wins hold");

    // R10: identical rewrite raises no flag
    wr24(4'd0, 24'h000000);
    done("R10 same value");
    checkHold("R10 same value hold");

    tick(4);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule